// File: doc/BRIEF.md
# Infrared Controller Advanced Status Register

This block holds the eight-bit advanced status register of an infrared serial controller. The controller runs in one of two framed high-speed modes (MIR or FIR) or in a remote-control pulse mode. Hardware event inputs from the receiver, the transmitter and the flow-control logic set flags in the register. A host port reads and writes it. Some flags clear when the host reads the register. The underrun flag clears only when the host writes a 1 to it. Some flags follow live conditions. The meaning of two flags changes with the operating mode.

The register also tracks how a transmit frame ends. In PIO mode, software writes a frame-end command bit once it has written the frame data. In DMA mode, a terminal count from the DMA engine plays the same role. When the transmitter runs empty, the block raises a one-cycle clean-end pulse if a frame end was signalled. If none was signalled, it sets the underrun flag instead.

Top module: `irc_adv_status`

## Requirements
- R1: After a synchronous active-low reset, `rd_data_o` reads 0x00 and `frame_clean_o` is 0.
- R2: Bit 7 (flow control) is set by `ev_flow_i`. Bit 0 (receive or status timeout) is set by `ev_rx_tmo_i`. Both clear on the clock edge that ends a cycle with `rd_en_i` high. During that read cycle, `rd_data_o` still shows the value before the clear.
- R3: If a set event arrives in the same cycle as a clearing read, the bit stays set.
- R4: Bit 6 (underrun) is set when `ev_tx_empty_i` arrives and no frame end has been signalled. Reads leave it unchanged. Only a write with data bit 6 equal to 1 clears it.
- R5: In PIO mode (`dma_mode_i`=0), a host write loads data bit 3 into bit 3 (frame end). When `ev_tx_empty_i` arrives while bit 3 is 1, three things happen: bit 3 clears, underrun is not set, and `frame_clean_o` is high for one cycle after that edge. A write in the same cycle takes priority over the self-clear.
- R6: In DMA mode, a `dma_tc_i` pulse counts as the frame end for the next `ev_tx_empty_i`. The pulse may arrive in that same cycle or at any cycle since the last empty. This gives the clean-end pulse instead of underrun.
- R7: While `dma_mode_i` is 1, bit 3 reads 0 and host writes to it are ignored.
- R8: Bit 2 always reads 0. Writes have no effect on bits 7, 5, 4, 2, 1 or 0.
- R9: Mode encoding on `mode_i` is 00 = MIR, 01 = FIR, and 10 or 11 = remote. Bit 5 shows, one cycle later, `rx_busy_i` in MIR or FIR and `rc_rx_act_i` in remote mode.
- R10: Bit 4 is sticky and clears on read. In MIR or FIR it is set by `ev_lost_fend_i`. In remote mode it is set by `ev_rc_pulse_i`. The source for the other mode is ignored.
- R11: In any cycle where `mode_i` differs from its value in the previous cycle, bits 5 and 4 become 0 on that edge. Events in that cycle are ignored for those two bits.
- R12: Bit 1 shows, one cycle later, `fend_in_fifo_i` in MIR or FIR, and reads 0 in remote mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 MIR, 01 FIR, 1x remote |
| dma_mode_i | input | 1 | 1 = DMA transfer, 0 = PIO |
| rd_en_i | input | 1 | Host read strobe for the register |
| wr_en_i | input | 1 | Host write strobe for the register |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Register contents |
| ev_flow_i | input | 1 | Flow-control event pulse |
| ev_tx_empty_i | input | 1 | Transmitter ran empty (pulse) |
| dma_tc_i | input | 1 | DMA terminal count pulse |
| rx_busy_i | input | 1 | Framed receiver busy (level) |
| rc_rx_act_i | input | 1 | Remote receiver in process (level) |
| ev_lost_fend_i | input | 1 | Framed: frame end lost (pulse) |
| ev_rc_pulse_i | input | 1 | Remote: pulse(s) detected |
| fend_in_fifo_i | input | 1 | Frame end still held in receive FIFO (level) |
| ev_rx_tmo_i | input | 1 | Receive or frame-status FIFO timeout (pulse) |
| frame_clean_o | output | 1 | One-cycle pulse: transmit frame ended with a frame end |

## Verification
Several pairs of functions can land in the same cycle. A flow-control or timeout event can coincide with the host read that clears the flag. The transmitter can empty in the same cycle as a terminal count, or as a host write to the frame-end bit. A mode switch can coincide with a lost-frame or remote-pulse event. The vector table drives each pair together in one cycle. It then checks the register on the following edge: the set must survive the read, the coincident terminal count must give a clean end, the write must win over the self-clear, and the mode switch must wipe bits 5 and 4.

// File: rtl/irc_pkg.sv
// Shared types and bit positions of the advanced IR status register.
// Assumes an eight-bit register; positions are fixed by software decoding.
package irc_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        IRC_MIR    = 2'b00,
        IRC_FIR    = 2'b01,
        IRC_RC     = 2'b10,
        IRC_RC_ALT = 2'b11
    } irc_mode_e;

    localparam int B_FLOW   = 7;
    localparam int B_UNDRN  = 6;
    localparam int B_BUSY   = 5;
    localparam int B_EVT4   = 4;
    localparam int B_FEND   = 3;
    localparam int B_RSVD   = 2;
    localparam int B_FIFOFE = 1;
    localparam int B_TMO    = 0;

    // Number of clear-on-read sticky flags (bits 7, 4, 0).
    localparam int N_COR = 3;
endpackage

// File: rtl/irc_sticky_bank.sv
// Bank of sticky flags that clear on a host read.
// A set in the same cycle as the read wins; a forced clear beats both.
// Assumes set, read-clear and forced-clear are all single-cycle qualified.
module irc_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] rd_clr_i,
    input  logic [N-1:0] force_clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        // Hold, set or clear one flag.
        always_ff @(posedge clk) begin
            if (!rst_n)               q <= 1'b0;
            else if (force_clr_i[g])  q <= 1'b0;
            else                      q <= set_i[g] | (q & ~rd_clr_i[g]);
        end
        assign flag_o[g] = q;
    end
endmodule

// File: rtl/irc_mode_route.sv
// Routes mode-dependent event sources and detects a change of mode.
// Assumes mode_i is stable within a cycle; the previous mode is kept
// without reset so a change is always judged against the last sample.
module irc_mode_route
    import irc_pkg::*;
(
    input  logic       clk,
    input  logic [1:0] mode_i,
    input  logic       rx_busy_i,
    input  logic       rc_rx_act_i,
    input  logic       ev_lost_fend_i,
    input  logic       ev_rc_pulse_i,
    input  logic       fend_in_fifo_i,
    output logic       remote_o,
    output logic       mode_chg_o,
    output logic       busy_sel_o,
    output logic       evt4_sel_o,
    output logic       fifofe_sel_o
);
    logic [1:0] mode_q;

    // Remember the mode seen on the previous edge.
    always_ff @(posedge clk) begin
        mode_q <= mode_i;
    end

    // Select sources for the current mode.
    always_comb begin
        remote_o     = (mode_i == IRC_RC) || (mode_i == IRC_RC_ALT);
        mode_chg_o   = (mode_i != mode_q);
        busy_sel_o   = remote_o ? rc_rx_act_i   : rx_busy_i;
        evt4_sel_o   = remote_o ? ev_rc_pulse_i : ev_lost_fend_i;
        fifofe_sel_o = remote_o ? 1'b0          : fend_in_fifo_i;
    end
endmodule

// File: rtl/irc_fend_ctl.sv
// Transmit frame-end tracking: software frame-end bit (PIO), remembered
// terminal count (DMA), underrun flag (write-1-to-clear), clean-end pulse.
// Assumes ev_tx_empty_i is a single-cycle pulse per frame.
module irc_fend_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_mode_i,
    input  logic wr_en_i,
    input  logic wd_fend_i,
    input  logic wd_undrn_i,
    input  logic ev_tx_empty_i,
    input  logic dma_tc_i,
    output logic fend_o,
    output logic undrn_o,
    output logic clean_o
);
    logic fend_q, tc_seen_q, undrn_q, clean_q;
    logic armed;

    // A frame end is pending when PIO bit or any terminal count is present.
    always_comb begin
        armed = dma_mode_i ? (dma_tc_i | tc_seen_q) : fend_q;
    end

    // Software frame-end bit: write wins, then self-clear on consume.
    always_ff @(posedge clk) begin
        if (!rst_n)              fend_q <= 1'b0;
        else if (dma_mode_i)     fend_q <= 1'b0;
        else if (wr_en_i)        fend_q <= wd_fend_i;
        else if (ev_tx_empty_i)  fend_q <= 1'b0;
    end

    // Terminal count memory until the transmitter empties.
    always_ff @(posedge clk) begin
        if (!rst_n)              tc_seen_q <= 1'b0;
        else if (ev_tx_empty_i)  tc_seen_q <= 1'b0;
        else if (dma_tc_i)       tc_seen_q <= 1'b1;
    end

    // Underrun: set on empty without frame end, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) undrn_q <= 1'b0;
        else        undrn_q <= (ev_tx_empty_i & ~armed) |
                               (undrn_q & ~(wr_en_i & wd_undrn_i));
    end

    // One-cycle pulse for a frame that ended cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) clean_q <= 1'b0;
        else        clean_q <= ev_tx_empty_i & armed;
    end

    assign fend_o  = fend_q;
    assign undrn_o = undrn_q;
    assign clean_o = clean_q;
endmodule

// File: rtl/irc_adv_status.sv
// Advanced status register of an infrared controller. Combines sticky
// clear-on-read flags, the transmit frame-end logic and mode-dependent
// live bits into one host-readable byte. Assumes a single host port
// with one-cycle read and write strobes; reads have no latency.
module irc_adv_status
    import irc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             dma_mode_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             ev_flow_i,
    input  logic             ev_tx_empty_i,
    input  logic             dma_tc_i,
    input  logic             rx_busy_i,
    input  logic             rc_rx_act_i,
    input  logic             ev_lost_fend_i,
    input  logic             ev_rc_pulse_i,
    input  logic             fend_in_fifo_i,
    input  logic             ev_rx_tmo_i,
    output logic             frame_clean_o
);
    localparam int I_FLOW = 2;
    localparam int I_EVT4 = 1;
    localparam int I_TMO  = 0;

    logic remote, mode_chg, busy_sel, evt4_sel, fifofe_sel;
    logic [N_COR-1:0] cor_set, cor_rd, cor_force, cor_q;
    logic fend, undrn, busy_q, fifofe_q;

    irc_mode_route u_route (
        .clk            (clk),
        .mode_i         (mode_i),
        .rx_busy_i      (rx_busy_i),
        .rc_rx_act_i    (rc_rx_act_i),
        .ev_lost_fend_i (ev_lost_fend_i),
        .ev_rc_pulse_i  (ev_rc_pulse_i),
        .fend_in_fifo_i (fend_in_fifo_i),
        .remote_o       (remote),
        .mode_chg_o     (mode_chg),
        .busy_sel_o     (busy_sel),
        .evt4_sel_o     (evt4_sel),
        .fifofe_sel_o   (fifofe_sel)
    );

    // Build set, read-clear and forced-clear vectors for the sticky flags.
    always_comb begin
        cor_set           = '0;
        cor_set[I_FLOW]   = ev_flow_i;
        cor_set[I_EVT4]   = evt4_sel;
        cor_set[I_TMO]    = ev_rx_tmo_i;
        cor_rd            = {N_COR{rd_en_i}};
        cor_force         = '0;
        cor_force[I_EVT4] = mode_chg;
    end

    irc_sticky_bank #(.N(N_COR)) u_cor (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (cor_set),
        .rd_clr_i    (cor_rd),
        .force_clr_i (cor_force),
        .flag_o      (cor_q)
    );

    irc_fend_ctl u_fend (
        .clk           (clk),
        .rst_n         (rst_n),
        .dma_mode_i    (dma_mode_i),
        .wr_en_i       (wr_en_i),
        .wd_fend_i     (wr_data_i[B_FEND]),
        .wd_undrn_i    (wr_data_i[B_UNDRN]),
        .ev_tx_empty_i (ev_tx_empty_i),
        .dma_tc_i      (dma_tc_i),
        .fend_o        (fend),
        .undrn_o       (undrn),
        .clean_o       (frame_clean_o)
    );

    // Registered live bits: receiver activity and leftover frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            fifofe_q <= 1'b0;
        end else begin
            busy_q   <= mode_chg ? 1'b0 : busy_sel;
            fifofe_q <= fifofe_sel;
        end
    end

    // Assemble the register image presented to the host.
    always_comb begin
        rd_data_o           = '0;
        rd_data_o[B_FLOW]   = cor_q[I_FLOW];
        rd_data_o[B_UNDRN]  = undrn;
        rd_data_o[B_BUSY]   = busy_q;
        rd_data_o[B_EVT4]   = cor_q[I_EVT4];
        rd_data_o[B_FEND]   = fend;
        rd_data_o[B_RSVD]   = 1'b0;
        rd_data_o[B_FIFOFE] = fifofe_q;
        rd_data_o[B_TMO]    = cor_q[I_TMO];
    end

    logic unused_remote;
    assign unused_remote = remote;
endmodule

// File: rtl/irc_adv_status_chk.sv
// Property checker for the advanced status register, bound to the top.
module irc_adv_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       dma_mode_i,
    input logic       rd_en_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       ev_flow_i,
    input logic       ev_tx_empty_i,
    input logic       frame_clean_o
);
    // R2: a read with no flow event clears bit 7.
    a_r2_read_clears_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ev_flow_i) |=> !rd_data_o[7]);

    // R3: a flow event always shows on the next cycle, read or not.
    a_r3_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flow_i |=> rd_data_o[7]);

    // R4: underrun only falls after a write of 1 to bit 6.
    a_r4_undrn_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data_o[6]) |-> $past(wr_en_i && wr_data_i[6]));

    // R5: no clean-end pulse without a transmitter-empty event.
    a_r5_clean_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_tx_empty_i |=> !frame_clean_o);

    // R7: frame-end bit stays 0 in DMA mode.
    a_r7_dma_fend_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode_i |=> !rd_data_o[3]);

    // R8: reserved bit reads 0.
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[2]);

    // R11: a mode change clears bits 5 and 4.
    a_r11_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |=> (rd_data_o[5:4] == 2'b00));
endmodule

bind irc_adv_status irc_adv_status_chk chk_i (.*);

// File: tb/irc_adv_status_tb_top.sv
`timescale 1ns/1ps
module irc_adv_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       dma_mode_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       ev_flow_i = 0, ev_tx_empty_i = 0, dma_tc_i = 0, rx_busy_i = 0;
    logic       rc_rx_act_i = 0, ev_lost_fend_i = 0, ev_rc_pulse_i = 0;
    logic       fend_in_fifo_i = 0, ev_rx_tmo_i = 0;
    logic       frame_clean_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irc_adv_status dut_i (.*);

    // Vector: {req[4], mode[2], dma, rd, wr, wdata[8], ev[9], exp[8], clean}
    // ev = {flow, tx_empty, tc, rx_busy, rc_act, lost, pulse, fifo_fe, tmo}
    localparam int NV = 30;
    localparam logic [34:0] VEC [NV] = '{
        {4'd1, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h000,8'h00,1'b0}, // R1 idle
        {4'd2, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h100,8'h80,1'b0}, // R2 flow set
        {4'd2, 2'd0,1'b0,1'b1,1'b0,8'h00,9'h000,8'h00,1'b0}, // R2 read clears
        {4'd3, 2'd0,1'b0,1'b1,1'b0,8'h00,9'h100,8'h80,1'b0}, // R3 set wins
        {4'd2, 2'd0,1'b0,1'b1,1'b0,8'h00,9'h000,8'h00,1'b0}, // R2
        {4'd4, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h080,8'h40,1'b0}, // R4 underrun
        {4'd4, 2'd0,1'b0,1'b1,1'b0,8'h00,9'h000,8'h40,1'b0}, // R4 read keeps
        {4'd4, 2'd0,1'b0,1'b0,1'b1,8'h40,9'h000,8'h00,1'b0}, // R4 w1c
        {4'd5, 2'd0,1'b0,1'b0,1'b1,8'h08,9'h000,8'h08,1'b0}, // R5 arm
        {4'd5, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h080,8'h00,1'b1}, // R5 clean end
        {4'd8, 2'd0,1'b0,1'b0,1'b1,8'hFF,9'h000,8'h08,1'b0}, // R8 writes ignored
        {4'd5, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h000,8'h08,1'b0}, // R5 holds
        {4'd7, 2'd0,1'b1,1'b0,1'b0,8'h00,9'h000,8'h00,1'b0}, // R7 dma forces 0
        {4'd7, 2'd0,1'b1,1'b0,1'b1,8'h08,9'h000,8'h00,1'b0}, // R7 write ignored
        {4'd6, 2'd0,1'b1,1'b0,1'b0,8'h00,9'h040,8'h00,1'b0}, // R6 tc early
        {4'd6, 2'd0,1'b1,1'b0,1'b0,8'h00,9'h080,8'h00,1'b1}, // R6 clean end
        {4'd6, 2'd0,1'b1,1'b0,1'b0,8'h00,9'h080,8'h40,1'b0}, // R6 no tc
        {4'd6, 2'd0,1'b1,1'b0,1'b0,8'h00,9'h0C0,8'h40,1'b1}, // R6 tc same cycle
        {4'd4, 2'd0,1'b1,1'b0,1'b1,8'h40,9'h000,8'h00,1'b0}, // R4 w1c
        {4'd9, 2'd0,1'b0,1'b0,1'b0,8'h00,9'h020,8'h20,1'b0}, // R9 busy
        {4'd12,2'd0,1'b0,1'b0,1'b0,8'h00,9'h02B,8'h33,1'b0}, // R12 fifo fe
        {4'd10,2'd0,1'b0,1'b0,1'b0,8'h00,9'h014,8'h11,1'b0}, // R10 remote src ignored
        {4'd11,2'd2,1'b0,1'b0,1'b0,8'h00,9'h016,8'h01,1'b0}, // R11 switch to remote
        {4'd10,2'd2,1'b0,1'b0,1'b0,8'h00,9'h01C,8'h31,1'b0}, // R10 pulse, lost ignored
        {4'd10,2'd2,1'b0,1'b1,1'b0,8'h00,9'h000,8'h00,1'b0}, // R10 read clears
        {4'd3, 2'd2,1'b0,1'b1,1'b0,8'h00,9'h001,8'h01,1'b0}, // R3 timeout wins
        {4'd11,2'd1,1'b0,1'b0,1'b0,8'h00,9'h028,8'h01,1'b0}, // R11 switch to FIR
        {4'd2, 2'd1,1'b0,1'b1,1'b0,8'h00,9'h000,8'h00,1'b0}, // R2 timeout read
        {4'd5, 2'd1,1'b0,1'b0,1'b1,8'h08,9'h080,8'h48,1'b0}, // R5 write beats empty
        {4'd5, 2'd1,1'b0,1'b0,1'b1,8'h40,9'h080,8'h00,1'b1}  // R5 consume + w1c
    };

    task automatic check8(input int req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        {ev_flow_i, ev_tx_empty_i, dma_tc_i, rx_busy_i, rc_rx_act_i,
         ev_lost_fend_i, ev_rc_pulse_i, fend_in_fifo_i, ev_rx_tmo_i} = '0;
        rd_en_i = 0; wr_en_i = 0; wr_data_i = 8'h00;
    endtask

    initial begin
        drive_idle();
        repeat (3) @(posedge clk);
        #1 check8(1, "reset data", rd_data_o, 8'h00);   // R1
        check8(1, "reset clean", {7'd0, frame_clean_o}, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_i     = VEC[i][30:29];
            dma_mode_i = VEC[i][28];
            rd_en_i    = VEC[i][27];
            wr_en_i    = VEC[i][26];
            wr_data_i  = VEC[i][25:18];
            {ev_flow_i, ev_tx_empty_i, dma_tc_i, rx_busy_i, rc_rx_act_i,
             ev_lost_fend_i, ev_rc_pulse_i, fend_in_fifo_i, ev_rx_tmo_i} = VEC[i][17:9];
            @(posedge clk);
            #1;
            check8(int'(VEC[i][34:31]), $sformatf("vector %0d data", i),
                   rd_data_o, VEC[i][8:1]);
            check8(int'(VEC[i][34:31]), $sformatf("vector %0d clean", i),
                   {7'd0, frame_clean_o}, {7'd0, VEC[i][0]});
        end

        // R2: read data shows the pre-clear value during the read cycle.
        @(negedge clk) drive_idle(); ev_flow_i = 1;
        @(negedge clk) ev_flow_i = 0; rd_en_i = 1;
        #1 check8(2, "value during read", rd_data_o, 8'h80);
        @(negedge clk) rd_en_i = 0;
        check8(2, "value after read", rd_data_o, 8'h00);

        // R1: reset in mid-run clears set flags.
        @(negedge clk) ev_flow_i = 1; ev_tx_empty_i = 1;
        @(negedge clk) drive_idle();
        check8(4, "flags before reset", rd_data_o, 8'h40 | 8'h80);
        rst_n = 0;
        @(posedge clk) #1;
        check8(1, "mid-run reset data", rd_data_o, 8'h00);
        check8(1, "mid-run reset clean", {7'd0, frame_clean_o}, 8'h00);
        @(negedge clk) rst_n = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule